// File: doc/BRIEF.md
# Mixed-Precision Integer Matrix Multiply-Accumulate Array

This block carries out one small matrix multiply-accumulate for every issue, in one of two signed integer modes. In byte mode, a 4×8 matrix of signed bytes is multiplied by an 8×4 matrix of signed bytes. The 4×4 product is added into sixteen 32-bit accumulators. In halfword mode, two 4×4 matrices of signed 16-bit values are multiplied and the product is added into sixteen 64-bit accumulators.

Both operands arrive as single 256-bit register images. The second operand is held as four rows, and row j of that image provides column j of the product, so it is transposed where it enters the multipliers. The accumulator arrives as a 1024-bit group of consecutive registers: byte mode uses the lower two registers and halfword mode uses all four. The updated group comes back on the same packing.

A fixed two-stage pipeline sits between issue and result. The first stage registers every partial product. The second stage reduces the partial products, adds the incoming accumulator and registers the outcome.

Top module: `imma_core`

## Requirements
- R1: With `in_mode`=0 (byte mode), let A[i][k] be the signed byte `opa[8*(8i+k)+:8]` and B[j][k] the signed byte `opb[8*(8i+k)+:8]` read with row j in place of i. The result element (i,j) at `acc_out[32*(4i+j)+:32]` then equals `acc_in[32*(4i+j)+:32]` plus the sum over k=0..7 of A[i][k]*B[j][k].
- R2: In byte mode every 32-bit element wraps modulo 2^32 and never saturates.
- R3: In byte mode `acc_out[1023:512]` is zero, and `acc_in[1023:512]` has no effect on the result.
- R4: With `in_mode`=1 (halfword mode), let A[i][k] be `opa[16*(4i+k)+:16]` and B[j][k] be `opb[16*(4j+k)+:16]`, both signed. The result element (i,j) at `acc_out[64*(4i+j)+:64]` then equals `acc_in[64*(4i+j)+:64]` plus the sum over k=0..3 of A[i][k]*B[j][k].
- R5: In halfword mode every 64-bit element wraps modulo 2^64.
- R6: All operands and accumulators are two's complement signed values, including the most negative values (-128, -32768).
- R7: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, and the result of that issue is on `acc_out` in the same cycle. Issues on consecutive cycles each give their own result, even when they mix modes.
- R8: While `out_valid` is low, `acc_out` holds its last value, and inputs presented with `in_valid` low have no effect on it.
- R9: Synchronous active-high `rst` clears `out_valid` and `acc_out` to zero by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one multiply-accumulate |
| in_mode | input | 1 | 0 = byte mode, 1 = halfword mode |
| opa | input | 256 | Left operand, four rows |
| opb | input | 256 | Right operand, four rows, each a product column |
| acc_in | input | 1024 | Accumulator group being updated |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 1024 | Updated accumulator group |

## Verification
Two conditions are hard to reach with random data alone. The first is an accumulator element that wraps around its width. The second is a product of two most-negative operands. Random data almost never produces either, so the stimulus drives them on purpose: every byte or halfword is set to the minimum value, and the accumulator inputs sit just below the signed maximum. The other difficult case is a run of issues on consecutive cycles that switch mode from one cycle to the next, which mixes both result packings inside the pipeline. A dense burst with a mode chosen at random on each cycle covers it, and a reference model compares the full 1024-bit result on every clock.

// File: rtl/imma_pkg.sv
package imma_pkg;
  typedef enum logic {
    MODE_I8  = 1'b0,
    MODE_I16 = 1'b1
  } imma_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
endpackage

// File: rtl/imma_prod.sv
// Partial products for one output cell: one operand-A row against one operand-B row.
module imma_prod
  import imma_pkg::*;
#(
  parameter int unsigned ROW_W = 64,
  parameter int unsigned PW    = 32
) (
  input  imma_mode_e             mode,
  input  logic [ROW_W-1:0]       a_row,
  input  logic [ROW_W-1:0]       b_row,
  output logic [(ROW_W/BYTE_W)*PW-1:0] prods
);
  localparam int unsigned K8  = ROW_W / BYTE_W;
  localparam int unsigned K16 = ROW_W / HALF_W;

  for (genvar k = 0; k < K8; k++) begin : g_lane
    logic signed [2*BYTE_W-1:0] p_byte;
    assign p_byte = $signed(a_row[BYTE_W*k +: BYTE_W]) * $signed(b_row[BYTE_W*k +: BYTE_W]);

    if (k < K16) begin : g_wide
      logic signed [2*HALF_W-1:0] p_half;
      assign p_half = $signed(a_row[HALF_W*k +: HALF_W]) * $signed(b_row[HALF_W*k +: HALF_W]);
      always_comb begin
        if (mode == MODE_I16)
          prods[PW*k +: PW] = {{(PW-2*HALF_W){p_half[2*HALF_W-1]}}, p_half};
        else
          prods[PW*k +: PW] = {{(PW-2*BYTE_W){p_byte[2*BYTE_W-1]}}, p_byte};
      end
    end else begin : g_narrow
      always_comb begin
        if (mode == MODE_I16)
          prods[PW*k +: PW] = '0;
        else
          prods[PW*k +: PW] = {{(PW-2*BYTE_W){p_byte[2*BYTE_W-1]}}, p_byte};
      end
    end
  end
endmodule

// File: rtl/imma_reduce.sv
// Adder tree plus accumulate for one output cell, wrapping at the mode's width.
module imma_reduce
  import imma_pkg::*;
#(
  parameter int unsigned K    = 8,
  parameter int unsigned PW   = 32,
  parameter int unsigned AW8  = 32,
  parameter int unsigned AW16 = 64
) (
  input  imma_mode_e          mode,
  input  logic [K*PW-1:0]     prods,
  input  logic [AW16-1:0]     acc_lane,
  output logic [AW16-1:0]     sum
);
  logic [AW16-1:0] total;

  always_comb begin
    total = acc_lane;
    for (int k = 0; k < K; k++) begin
      total = total + {{(AW16-PW){prods[PW*k+PW-1]}}, prods[PW*k +: PW]};
    end
    if (mode == MODE_I8)
      sum = {{(AW16-AW8){1'b0}}, total[AW8-1:0]};
    else
      sum = total;
  end
endmodule

// File: rtl/imma_core.sv
module imma_core
  import imma_pkg::*;
#(
  parameter int unsigned DIM   = 4,
  parameter int unsigned REG_W = 256,
  parameter int unsigned AW8   = 32,
  parameter int unsigned AW16  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_mode,
  input  logic [REG_W-1:0]           opa,
  input  logic [REG_W-1:0]           opb,
  input  logic [DIM*DIM*AW16-1:0]    acc_in,
  output logic                       out_valid,
  output logic [DIM*DIM*AW16-1:0]    acc_out
);
  localparam int unsigned ROW_W = REG_W / DIM;
  localparam int unsigned K8    = ROW_W / BYTE_W;
  localparam int unsigned PW    = 2 * HALF_W;
  localparam int unsigned CELLS = DIM * DIM;
  localparam int unsigned ACC_W = CELLS * AW16;
  localparam int unsigned CP_W  = K8 * PW;

  imma_mode_e mode_in;
  assign mode_in = imma_mode_e'(in_mode);

  // Stage 1: partial products
  logic [CELLS*CP_W-1:0] prod_c;
  logic [CELLS*CP_W-1:0] s1_prod;
  logic                  s1_valid;
  imma_mode_e            s1_mode;
  logic [ACC_W-1:0]      s1_acc;

  for (genvar i = 0; i < DIM; i++) begin : g_row
    for (genvar j = 0; j < DIM; j++) begin : g_col
      imma_prod #(.ROW_W(ROW_W), .PW(PW)) u_prod (
        .mode  (mode_in),
        .a_row (opa[ROW_W*i +: ROW_W]),
        .b_row (opb[ROW_W*j +: ROW_W]),
        .prods (prod_c[CP_W*(DIM*i+j) +: CP_W])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    if (in_valid) begin
      s1_prod <= prod_c;
      s1_mode <= mode_in;
      s1_acc  <= acc_in;
    end
  end

  // Stage 2: reduction and accumulate
  logic [CELLS*AW16-1:0] sum_c;
  logic [ACC_W-1:0]      res_c;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [AW16-1:0] lane;
    assign lane = (s1_mode == MODE_I8)
                ? {{(AW16-AW8){1'b0}}, s1_acc[AW8*c +: AW8]}
                : s1_acc[AW16*c +: AW16];
    imma_reduce #(.K(K8), .PW(PW), .AW8(AW8), .AW16(AW16)) u_red (
      .mode     (s1_mode),
      .prods    (s1_prod[CP_W*c +: CP_W]),
      .acc_lane (lane),
      .sum      (sum_c[AW16*c +: AW16])
    );
  end

  always_comb begin
    res_c = '0;
    for (int c = 0; c < CELLS; c++) begin
      if (s1_mode == MODE_I8) res_c[AW8*c +: AW8]   = sum_c[AW16*c +: AW8];
      else                    res_c[AW16*c +: AW16] = sum_c[AW16*c +: AW16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) acc_out <= res_c;
    end
  end

  // Assertions
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(acc_out));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode, 2) == 1'b0) |-> (acc_out[ACC_W-1:ACC_W/2] == '0));

  a_r1_zero_a_passes_acc: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode, 2) == 1'b0 && $past(opa, 2) == '0)
      |-> (acc_out[ACC_W/2-1:0] == $past(acc_in[ACC_W/2-1:0], 2)));

  a_r4_zero_a_passes_acc: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(in_mode, 2) == 1'b1 && $past(opa, 2) == '0)
      |-> (acc_out == $past(acc_in, 2)));

  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && acc_out == '0));
endmodule

// File: tb/sim_imma_core.sv
module sim_imma_core;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_mode = 1'b0;
  logic [255:0] opa = '0;
  logic [255:0] opb = '0;
  logic [ACC_W-1:0] acc_in = '0;
  logic out_valid;
  logic [ACC_W-1:0] acc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  imma_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .opa(opa), .opb(opb), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  function automatic logic [ACC_W-1:0] model(input logic m, input logic [255:0] a,
                                              input logic [255:0] b, input logic [ACC_W-1:0] acc);
    logic [ACC_W-1:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        longint s;
        if (!m) begin
          s = longint'($signed(acc[32*(4*i+j) +: 32]));
          for (int k = 0; k < 8; k++)
            s += longint'($signed(a[8*(8*i+k) +: 8])) * longint'($signed(b[8*(8*j+k) +: 8]));
          r[32*(4*i+j) +: 32] = s[31:0];
        end else begin
          s = longint'(acc[64*(4*i+j) +: 64]);
          for (int k = 0; k < 4; k++)
            s += longint'($signed(a[16*(4*i+k) +: 16])) * longint'($signed(b[16*(4*j+k) +: 16]));
          r[64*(4*i+j) +: 64] = s;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [ACC_W-1:0] rnd_vec();
    logic [ACC_W-1:0] v;
    for (int w = 0; w < ACC_W/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  // Reference pipeline, behavioural
  logic p_v = 1'b0;
  logic [ACC_W-1:0] p_d = '0;
  logic exp_v = 1'b0;
  logic [ACC_W-1:0] exp_d = '0;

  always @(posedge clk) begin
    if (rst) begin
      p_v <= 1'b0; exp_v <= 1'b0; exp_d <= '0;
    end else begin
      exp_v <= p_v;
      if (p_v) exp_d <= p_d;
      p_v <= in_valid;
      if (in_valid) p_d <= model(in_mode, opa, opb, acc_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v || acc_out !== exp_d) begin
        errors++;
        $display("FAIL %s: out_valid=%0b acc_out=%h expected out_valid=%0b acc_out=%h",
                 cur_req, out_valid, acc_out, exp_v, exp_d);
      end
    end
  end

  task automatic check1(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic issue(input logic m, input logic [255:0] a, input logic [255:0] b,
                       input logic [ACC_W-1:0] acc);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; opa = a; opb = b; acc_in = acc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      opa = rnd_vec()[255:0]; opb = rnd_vec()[255:0]; acc_in = rnd_vec();
      in_mode = $urandom % 2;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [ACC_W-1:0] big;
    // R9 reset state
    cur_req = "R9";
    repeat (4) @(negedge clk);
    check1("R9 out_valid", out_valid, 1'b0);
    check1("R9 acc_out zero", acc_out == '0, 1'b1);
    rst = 1'b0;
    idle(2);

    // R1 byte mode, random, R3 with random upper accumulator bits
    cur_req = "R1/R3";
    for (int n = 0; n < 20; n++) begin
      issue(1'b0, rnd_vec()[255:0], rnd_vec()[255:0], rnd_vec());
      idle(n % 3);
    end
    idle(3);
    check1("R3 upper half zero", acc_out[1023:512] == '0, 1'b1);

    // R6 most-negative bytes: each element 8*16384
    cur_req = "R6";
    issue(1'b0, {32{8'h80}}, {32{8'h80}}, '0);
    idle(2);
    check1("R6 byte -128*-128 sum", acc_out[31:0] == 32'd131072, 1'b1);

    // R2 byte wrap
    cur_req = "R2";
    issue(1'b0, {32{8'h7F}}, {32{8'h7F}}, {32{32'h7FFF_FFF0}});
    idle(3);
    issue(1'b0, {32{8'h80}}, {32{8'h7F}}, {32{32'h8000_0005}});
    idle(3);

    // R4 halfword random
    cur_req = "R4";
    for (int n = 0; n < 20; n++) begin
      issue(1'b1, rnd_vec()[255:0], rnd_vec()[255:0], rnd_vec());
      idle(n % 2);
    end
    idle(3);

    // R5 halfword wrap with R6 extremes
    cur_req = "R5";
    big = {16{64'h7FFF_FFFF_FFFF_FFFF}};
    issue(1'b1, {16{16'h8000}}, {16{16'h8000}}, big);
    idle(2);
    check1("R5 wrap to negative", acc_out[63], 1'b1);
    idle(2);

    // R7 latency of a single issue
    cur_req = "R7";
    issue(1'b0, rnd_vec()[255:0], rnd_vec()[255:0], rnd_vec());
    check1("R7 not early", out_valid, 1'b0);
    @(negedge clk);
    check1("R7 on time", out_valid, 1'b1);
    @(negedge clk);
    check1("R7 single pulse", out_valid, 1'b0);

    // R7 dense mixed-mode burst
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      in_valid = 1'b1; in_mode = $urandom % 2;
      opa = rnd_vec()[255:0]; opb = rnd_vec()[255:0]; acc_in = rnd_vec();
    end
    @(negedge clk);
    in_valid = 1'b0;
    idle(3);

    // R8 idle inputs have no effect
    cur_req = "R8";
    big = acc_out;
    idle(10);
    check1("R8 held", acc_out == big, 1'b1);

    // R9 reset mid-flight
    cur_req = "R9";
    @(negedge clk);
    in_valid = 1'b1; opa = rnd_vec()[255:0]; opb = rnd_vec()[255:0];
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check1("R9 valid cleared", out_valid, 1'b0);
    check1("R9 data cleared", acc_out == '0, 1'b1);
    rst = 1'b0;
    idle(4);

    finish_run();
  end
endmodule